// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Sequencer

This block frees an I2C bus that a target has left with SDA held low, for example after a reset in the middle of a read. On a start strobe it looks at the SDA level it receives. If SDA is already high, nothing needs doing: the block reports completion and never drives either line. If SDA is low, the block toggles SCL through open-drain pull-down enables. Each clock is a low phase followed by a release phase, and both phases are timed in microsecond ticks. After every clock it checks SDA again. Once SDA reads high, or once the clock budget is used up, it builds a STOP condition by overriding the lines in a fixed order and then lets go of both.

The controller is a single state machine with six states. `ST_IDLE` waits for a start request. It moves to `ST_CLK_LOW` when SDA is low, or to `ST_REPORT` when SDA is high. `ST_CLK_LOW` pulls SCL low and moves to `ST_CLK_HIGH` when the phase timer expires. `ST_CLK_HIGH` releases SCL. When its phase ends it returns to `ST_CLK_LOW` if SDA is still low and clocks remain. Otherwise it moves to `ST_STOP_BOTH`, which pulls both lines low. `ST_STOP_SDA` keeps SDA low with SCL released. `ST_REPORT` lasts one cycle, pulses the done flag and goes back to `ST_IDLE`. A separate phase timer counts ticks, and a pulse counter tracks the clock budget.

Top module: `i2c_bus_unstick`

## Requirements
- R1: A start request seen in `ST_IDLE` with `sda_i` low makes `busy_o` and `scl_pull_o` go high on the next clock edge. With `sda_i` high, neither line is ever pulled, `busy_o` stays low, and `done_o` pulses one cycle after the request with `failed_o` low.
- R2: Each recovery clock holds `scl_pull_o` high for exactly PHASE_TICKS ticks and then low for exactly PHASE_TICKS ticks. Every phase change happens on an edge where `tick_us_i` was high.
- R3: During the release phase of a recovery clock, ticks are counted only while `scl_i` reads high. A target that stretches the clock lengthens that phase and cannot shorten it.
- R4: SDA is sampled on the last tick of each release phase. Pulsing ends at the first sample that reads high.
- R5: No more than MAX_PULSES recovery clocks (default 10) are issued per request.
- R6: The closing sequence pulls SDA and SCL low together for PHASE_TICKS ticks. It then holds SDA low with SCL released for PHASE_TICKS ticks, then releases SDA. SDA is pulled low only while SCL is already pulled low, and SDA is released only after SCL has been released.
- R7: If SDA still reads low after the last allowed clock, the closing sequence still runs and `failed_o` is 1 when `done_o` pulses. `failed_o` stays at that value until the next accepted start request.
- R8: `busy_o` is high from the first pulled phase until the edge that releases both lines. `done_o` is a one-cycle pulse in the cycle right after that edge, and exactly one pulse follows each accepted request.
- R9: A start request while `busy_o` is high is ignored. The clock count and the closing sequence are unchanged.
- R10: While reset is asserted and directly after it, `scl_pull_o`, `sda_pull_o`, `busy_o`, `done_o` and `failed_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin recovery |
| tick_us_i | input | 1 | One-cycle microsecond timing tick |
| sda_i | input | 1 | Sampled SDA level (1 = high) |
| scl_i | input | 1 | Sampled SCL level (1 = high) |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| failed_o | output | 1 | SDA did not release within the clock budget |

## Verification
Most internal faults show up at the ports within one phase. A wrong state shows as a line pulled in the wrong order, or as a phase that lasts more or fewer than PHASE_TICKS ticks. A pulse counter that is off by one changes the number of SCL pulses the modelled target sees, and that count is visible as soon as the closing sequence starts. A fault in the failure flag appears at the done pulse or on any later cycle before the next request. Clock stretching checks that the timer stops while the bus is held and does not keep counting.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_STOP_BOTH,
        ST_STOP_SDA,
        ST_REPORT
    } unstick_state_t;

endpackage

// File: rtl/unstick_phase_timer.sv
module unstick_phase_timer #(
    parameter int PHASE_TICKS = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic tick_i,
    output logic end_o
);
    localparam int CW = $clog2(PHASE_TICKS + 1);

    logic [CW-1:0] cnt_q;

    assign end_o = tick_i && !hold_i && (cnt_q == CW'(PHASE_TICKS - 1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (hold_i || end_o) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CW'(PHASE_TICKS)); // R2

endmodule

// File: rtl/unstick_pulse_counter.sv
module unstick_pulse_counter #(
    parameter int MAX_PULSES = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int PW = $clog2(MAX_PULSES + 1);

    logic [PW-1:0] count_q;

    assign last_o = (count_q == PW'(MAX_PULSES - 1));

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    AST_PULSE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= PW'(MAX_PULSES)); // R5

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
    import unstick_pkg::*;
#(
    parameter int PHASE_TICKS = 6,
    parameter int MAX_PULSES  = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic tick_us_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o,
    output logic failed_o
);
    unstick_state_t state_q, state_d;
    logic phase_end, timer_hold, last_pulse, pulse_inc, fail_q;

    // Timer idles outside timed states and while a target stretches SCL.
    assign timer_hold = (state_q == ST_IDLE) || (state_q == ST_REPORT) ||
                        ((state_q == ST_CLK_HIGH) && !scl_i);
    assign pulse_inc  = (state_q == ST_CLK_HIGH) && phase_end;

    unstick_phase_timer #(.PHASE_TICKS(PHASE_TICKS)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (timer_hold),
        .tick_i (tick_us_i),
        .end_o  (phase_end)
    );

    unstick_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (state_q == ST_IDLE),
        .inc_i  (pulse_inc),
        .last_o (last_pulse)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = sda_i ? ST_REPORT : ST_CLK_LOW;
            ST_CLK_LOW:   if (phase_end) state_d = ST_CLK_HIGH;
            ST_CLK_HIGH:  if (phase_end) state_d = (sda_i || last_pulse) ? ST_STOP_BOTH : ST_CLK_LOW;
            ST_STOP_BOTH: if (phase_end) state_d = ST_STOP_SDA;
            ST_STOP_SDA:  if (phase_end) state_d = ST_REPORT;
            ST_REPORT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && start_i) begin
                fail_q <= 1'b0;
            end else if (pulse_inc && !sda_i && last_pulse) begin
                fail_q <= 1'b1;
            end
        end
    end

    always_comb begin
        scl_pull_o = (state_q == ST_CLK_LOW) || (state_q == ST_STOP_BOTH);
        sda_pull_o = (state_q == ST_STOP_BOTH) || (state_q == ST_STOP_SDA);
        busy_o     = (state_q == ST_CLK_LOW) || (state_q == ST_CLK_HIGH) ||
                     (state_q == ST_STOP_BOTH) || (state_q == ST_STOP_SDA);
        done_o     = (state_q == ST_REPORT);
        failed_o   = fail_q;
    end

    AST_BUSY_NEEDS_LOW_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i && !sda_i)); // R1
    AST_PHASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !$stable(scl_pull_o)) |-> $past(tick_us_i)); // R2
    AST_SDA_PULL_UNDER_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_pull_o) |-> scl_pull_o); // R6
    AST_SDA_RELEASE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sda_pull_o) |-> (!scl_pull_o && $past(!scl_pull_o))); // R6
    AST_FAIL_ON_LOW_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(failed_o) |-> $past(!sda_i)); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o); // R8

endmodule

// File: tb/i2c_bus_unstick_test.sv
module i2c_bus_unstick_test;
    localparam int PT = 6;
    localparam int MP = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tick = 1'b0;
    logic sda_in, scl_in;
    logic scl_pull, sda_pull, busy, done, failed;

    int n_run = 0, n_fail = 0;
    int tdiv = 0;
    bit stuck_en = 0;
    int release_after = 0, stretch_amt = 0, stretch_left = 0;
    int pulses_seen, low_ticks, high_ticks, both_ticks, sdaonly_ticks;
    int done_cnt, order_err, fail_at_done;
    logic prev_scl = 1'b0, prev_sda = 1'b0;

    always #4 clk = ~clk;

    assign sda_in = !(sda_pull || (stuck_en && (pulses_seen < release_after)));
    assign scl_in = !(scl_pull || (stretch_left > 0));

    i2c_bus_unstick #(.PHASE_TICKS(PT), .MAX_PULSES(MP)) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tick_us_i(tick),
        .sda_i(sda_in), .scl_i(scl_in), .scl_pull_o(scl_pull),
        .sda_pull_o(sda_pull), .busy_o(busy), .done_o(done), .failed_o(failed)
    );

    initial forever begin
        @(posedge clk); #2;
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    // Line monitor: samples mid-cycle the values the next edge will use.
    always @(negedge clk) begin
        if (tick && busy && scl_pull && !sda_pull) low_ticks++;
        if (tick && busy && !scl_pull && !sda_pull && scl_in) high_ticks++;
        if (tick && scl_pull && sda_pull) both_ticks++;
        if (tick && !scl_pull && sda_pull) sdaonly_ticks++;
        if (sda_pull && !prev_sda && !scl_pull) order_err++;
        if (!sda_pull && prev_sda && (scl_pull || prev_scl)) order_err++;
        if (done) begin done_cnt++; fail_at_done = failed; end
        if (scl_pull && !prev_scl && !sda_pull) pulses_seen++;
        if (stretch_left > 0) stretch_left--;
        if (prev_scl && !scl_pull && !sda_pull) stretch_left = stretch_amt;
        prev_scl = scl_pull;
        prev_sda = sda_pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk); #3;
        pulses_seen = 0; low_ticks = 0; high_ticks = 0; both_ticks = 0;
        sdaonly_ticks = 0; done_cnt = 0; order_err = 0; fail_at_done = -1;
    endtask

    task automatic test_reset();
        @(posedge clk); #3;
        chk({scl_pull, sda_pull, busy, done, failed} == 5'b0, "R10 outputs in reset",
            int'({scl_pull, sda_pull, busy, done, failed}), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #3;
        chk({scl_pull, sda_pull, busy, done, failed} == 5'b0, "R10 outputs after reset",
            int'({scl_pull, sda_pull, busy, done, failed}), 0);
    endtask

    task automatic test_bus_free();
        stuck_en = 0; stretch_amt = 0;
        clear_mon();
        start = 1'b1;
        @(posedge clk); #3; start = 1'b0;
        chk(done && !busy && !failed, "R1 free bus reports done at once",
            int'({done, busy, failed}), 4);
        repeat (40) @(posedge clk); #3;
        chk(low_ticks + both_ticks + sdaonly_ticks == 0 && !scl_pull && !sda_pull,
            "R1 free bus never pulled", low_ticks + both_ticks + sdaonly_ticks, 0);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
    endtask

    task automatic run_stuck(input string name, input int rel, input int str,
                             input int exp_p, input bit exp_f, input bit restart);
        stuck_en = 1; release_after = rel; stretch_amt = str;
        clear_mon();
        start = 1'b1;
        @(posedge clk); #3; start = 1'b0;
        chk(busy && scl_pull && !sda_pull, {"R1 recovery begins ", name},
            int'({busy, scl_pull, sda_pull}), 6);
        if (restart) begin
            repeat (30) @(posedge clk); #3;
            start = 1'b1;
            @(posedge clk); #3; start = 1'b0;
        end
        for (int i = 0; i < 5000 && done_cnt == 0; i++) @(posedge clk);
        repeat (10) @(posedge clk); #3;
        chk(pulses_seen == exp_p, {"R4 R5 pulse count ", name}, pulses_seen, exp_p);
        chk(low_ticks == PT * exp_p, {"R2 low-phase ticks ", name}, low_ticks, PT * exp_p);
        chk(high_ticks == PT * exp_p, {"R2 R3 release-phase ticks ", name}, high_ticks, PT * exp_p);
        chk(both_ticks == PT, {"R6 both-low ticks ", name}, both_ticks, PT);
        chk(sdaonly_ticks == PT, {"R6 SDA-only ticks ", name}, sdaonly_ticks, PT);
        chk(order_err == 0, {"R6 line order ", name}, order_err, 0);
        chk(done_cnt == 1, {"R8 R9 single done ", name}, done_cnt, 1);
        chk(fail_at_done == int'(exp_f), {"R7 failed at done ", name}, fail_at_done, int'(exp_f));
        chk(failed == exp_f && !busy && !scl_pull && !sda_pull, {"R7 R8 held after end ", name},
            int'({failed, busy, scl_pull, sda_pull}), int'(exp_f) * 8);
        stuck_en = 0; stretch_amt = 0;
    endtask

    initial begin
        test_reset();
        test_bus_free();
        run_stuck("release after 3", 3, 0, 3, 1'b0, 1'b0);
        run_stuck("release after 1", 1, 0, 1, 1'b0, 1'b0);
        run_stuck("never released", 1000, 0, MP, 1'b1, 1'b0);
        run_stuck("clear fail on restart", 2, 0, 2, 1'b0, 1'b0);
        run_stuck("stretched clock", 4, 10, 4, 1'b0, 1'b0);
        run_stuck("start while busy", 3, 0, 3, 1'b0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule